// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Frame Receiver

This block turns one asynchronous serial line into characters. A falling edge on the idle-high line opens a frame. The start bit is checked again near mid-bit. The data bits follow with the least significant bit first. An optional parity bit may come next, and then the stop bit. The line is read through a two-flop synchronizer. A prescaler makes sixteen sample ticks per bit period, and every bit value comes from a majority vote over three samples near the centre of the bit.

When the first stop bit has been sampled, the block raises a one-cycle strobe. With it come the character, a frame-error flag and a parity-error flag, and these values stay on the outputs until the next strobe. The data length, parity enable and parity sense are captured when the frame opens. An enable input gates reception. When the enable is cleared, any frame in progress is abandoned at once.

Top module: `sfr_rx`

## Requirements
- R1: A frame opens only on a high-to-low transition of the synchronized line, seen while idle. If the start-bit vote at mid-bit reads 1, the frame is dropped with no strobe, and the block waits for the next falling edge.
- R2: Each bit period is 16 ticks of CLKS_PER_TICK clocks. A bit is the 2-of-3 majority of the samples taken at ticks 7, 8 and 9, so one disturbed sample does not change the bit.
- R3: `len_i` codes 0 to 4 select 5 to 9 data bits, and codes 5 to 7 select 9. The first data bit received lands in `data_o[0]`. Bits of `data_o` at and above the data length read 0.
- R4: When `par_en_i` is 1, one parity bit follows the data. `par_odd_i`=0 requires an even count of ones over the data and parity bits, and 1 requires an odd count. A mismatch sets `par_err_o`. When parity is off, no parity bit is expected and `par_err_o` is 0.
- R5: `frame_err_o` is 1 when the first stop bit is voted 0, and 0 when it is voted 1.
- R6: Only the first stop bit is examined. Any further stop bits are idle line, and the next frame may start right after the first stop bit.
- R7: `valid_o` is high for exactly one cycle per completed frame. `data_o`, `frame_err_o` and `par_err_o` change only together with it and hold between strobes.
- R8: While `en_i` is 0 no strobe is produced, and a frame cut short by clearing `en_i` gives no strobe, even after reception is enabled again.
- R9: Length and parity settings are captured at the falling edge that opens a frame. Changes to them during that frame do not affect it.
- R10: After reset, `valid_o`, `data_o`, `frame_err_o` and `par_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Reception enable |
| rxd_i | input | 1 | Serial line, idle high |
| len_i | input | 3 | Data length code |
| par_en_i | input | 1 | Parity check enable |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| valid_o | output | 1 | One-cycle character strobe |
| data_o | output | 9 | Received character, zero-extended |
| frame_err_o | output | 1 | First stop bit read as 0 |
| par_err_o | output | 1 | Parity mismatch for this character |

## Verification
The hardest conditions to create from the ports are the rejected start bit and the abandoned frame. In both cases the correct result is that nothing happens, so the only evidence is that no strobe appears and that the held outputs do not change afterwards. The stimulus makes a low pulse too short to last until mid-bit, and it also drops the enable halfway through the data bits. After each case it sends a normal frame, to show that the receiver went back to hunting for a start edge. The bench also inverts one sample-wide slice of a data bit to exercise the vote, and it changes the settings after a frame has opened to check that they were captured at the start edge.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int OSR   = 16;
  localparam int PH_W  = $clog2(OSR);
  localparam int MAX_DW = 9;
  localparam int MIN_DW = 5;
  localparam int CNT_W = $clog2(MAX_DW + 1);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  function automatic logic [CNT_W-1:0] len_decode(input logic [2:0] code);
    if (code > 3'd4) return CNT_W'(MAX_DW);
    return CNT_W'(code) + CNT_W'(MIN_DW);
  endfunction
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/sfr_tick.sv
module sfr_tick #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/sfr_vote.sv
module sfr_vote
  import sfr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic            line_i,
  output logic            decide_o,
  output logic            bit_o
);
  localparam logic [PH_W-1:0] PH_A = PH_W'(OSR/2 - 1);
  localparam logic [PH_W-1:0] PH_B = PH_W'(OSR/2);
  localparam logic [PH_W-1:0] PH_C = PH_W'(OSR/2 + 1);

  logic s_a_q, s_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_a_q <= 1'b1;
      s_b_q <= 1'b1;
    end else if (tick_i) begin
      if (phase_i == PH_A) s_a_q <= line_i;
      if (phase_i == PH_B) s_b_q <= line_i;
    end
  end

  // third sample is the live line at the deciding tick
  assign decide_o = tick_i && (phase_i == PH_C);
  assign bit_o    = (s_a_q & s_b_q) | (s_a_q & line_i) | (s_b_q & line_i);
endmodule

// File: rtl/sfr_parity.sv
module sfr_parity #(
  parameter int DW = 9
) (
  input  logic [DW-1:0] data_i,
  input  logic          pbit_i,
  input  logic          odd_i,
  input  logic          en_i,
  output logic          err_o
);
  // unused data bits are zero, so a full-width reduction is exact
  assign err_o = en_i & (^data_i ^ pbit_i ^ odd_i);
endmodule

// File: rtl/sfr_rx.sv
module sfr_rx
  import sfr_pkg::*;
#(
  parameter int CLKS_PER_TICK = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rxd_i,
  input  logic [2:0]        len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              valid_o,
  output logic [MAX_DW-1:0] data_o,
  output logic              frame_err_o,
  output logic              par_err_o
);
  rx_state_e         state_q;
  logic              line, prev_q, fall;
  logic              tick, decide, vbit, pe_calc;
  logic [PH_W-1:0]   phase_q;
  logic [CNT_W-1:0]  idx_q, nbits_q;
  logic [MAX_DW-1:0] shift_q;
  logic              par_en_q, par_odd_q, pbit_q;
  logic              valid_q, fe_q, pe_q;
  logic [MAX_DW-1:0] data_q;

  sfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(line)
  );

  sfr_tick #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(!en_i || (state_q == ST_IDLE)), .tick_o(tick)
  );

  sfr_vote u_vote (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .phase_i(phase_q),
    .line_i(line), .decide_o(decide), .bit_o(vbit)
  );

  sfr_parity #(.DW(MAX_DW)) u_par (
    .data_i(shift_q), .pbit_i(pbit_q), .odd_i(par_odd_q),
    .en_i(par_en_q), .err_o(pe_calc)
  );

  assign fall = prev_q & ~line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      prev_q    <= 1'b1;
      phase_q   <= '0;
      idx_q     <= '0;
      nbits_q   <= CNT_W'(MAX_DW);
      shift_q   <= '0;
      par_en_q  <= 1'b0;
      par_odd_q <= 1'b0;
      pbit_q    <= 1'b0;
      valid_q   <= 1'b0;
      fe_q      <= 1'b0;
      pe_q      <= 1'b0;
      data_q    <= '0;
    end else begin
      prev_q  <= line;
      valid_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else begin
        if (tick) phase_q <= phase_q + PH_W'(1);
        unique case (state_q)
          ST_IDLE: if (fall) begin
            state_q   <= ST_START;
            phase_q   <= '0;
            idx_q     <= '0;
            shift_q   <= '0;
            pbit_q    <= 1'b0;
            nbits_q   <= len_decode(len_i);
            par_en_q  <= par_en_i;
            par_odd_q <= par_odd_i;
          end
          ST_START: if (decide) state_q <= vbit ? ST_IDLE : ST_DATA;
          ST_DATA: if (decide) begin
            shift_q[idx_q] <= vbit;
            idx_q          <= idx_q + CNT_W'(1);
            if (idx_q == nbits_q - CNT_W'(1))
              state_q <= par_en_q ? ST_PAR : ST_STOP;
          end
          ST_PAR: if (decide) begin
            pbit_q  <= vbit;
            state_q <= ST_STOP;
          end
          ST_STOP: if (decide) begin
            data_q  <= shift_q;
            fe_q    <= ~vbit;
            pe_q    <= pe_calc;
            valid_q <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign valid_o     = valid_q;
  assign data_o      = data_q;
  assign frame_err_o = fe_q;
  assign par_err_o   = pe_q;
endmodule

// File: rtl/sfr_rx_chk.sv
module sfr_rx_chk
  import sfr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              valid_o,
  input logic [MAX_DW-1:0] data_o,
  input logic              frame_err_o,
  input logic              par_err_o,
  input logic              par_en_q,
  input logic [CNT_W-1:0]  nbits_q,
  input rx_state_e         state_q
);
  a_r7_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r7_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(data_o) && $stable(frame_err_o) && $stable(par_err_o)));

  a_r7_idle_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (state_q == ST_IDLE));

  a_r8_no_strobe_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);

  a_r4_no_parity_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !par_en_q) |-> !par_err_o);

  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o >> nbits_q) == '0));
endmodule

bind sfr_rx sfr_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .valid_o(valid_o),
  .data_o(data_o), .frame_err_o(frame_err_o), .par_err_o(par_err_o),
  .par_en_q(par_en_q), .nbits_q(nbits_q), .state_q(state_q)
);

// File: tb/tb_sfr_rx.sv
module tb_sfr_rx;
  localparam int CPT = 4;
  localparam int BIT = 16 * CPT;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic [2:0] len_i = 3'd3;
  logic       par_en_i = 1'b0;
  logic       par_odd_i = 1'b0;
  logic       valid_o, frame_err_o, par_err_o;
  logic [8:0] data_o;

  int vectors = 0;
  int errors = 0;
  int strobes = 0;
  int cycles = 0;
  int exp_data[$];
  int exp_fe[$];
  int exp_pe[$];
  logic [8:0] last_data = '0;
  logic       last_fe = 1'b0, last_pe = 1'b0;

  always #10 clk = ~clk;

  sfr_rx #(.CLKS_PER_TICK(CPT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .rxd_i(rxd_i), .len_i(len_i),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i), .valid_o(valid_o),
    .data_o(data_o), .frame_err_o(frame_err_o), .par_err_o(par_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference: strobe matched against queued frames, held outputs checked every clock
  always @(negedge clk) begin
    if (rst_ni) begin
      if (valid_o) begin
        strobes++;
        if (exp_data.size() == 0) begin
          chk("R7 unexpected strobe", 1, 0);
        end else begin
          chk("R3 data", int'(data_o), exp_data.pop_front());
          chk("R5 frame error", int'(frame_err_o), exp_fe.pop_front());
          chk("R4 parity error", int'(par_err_o), exp_pe.pop_front());
        end
        last_data = data_o;
        last_fe = frame_err_o;
        last_pe = par_err_o;
      end else begin
        chk("R7 hold", int'({data_o, frame_err_o, par_err_o}),
            int'({last_data, last_fe, last_pe}));
      end
    end
  end

  task automatic send_frame(input int d, input int code, input bit pen, input bit podd,
                            input bit bad, input bit stopv, input int nstop,
                            input int glitch, input bit flip);
    int nb = (code > 4) ? 9 : code + 5;
    int msk = (1 << nb) - 1;
    int dm = d & msk;
    bit p = ($countones(dm) % 2 == 1) ^ podd ^ bad;
    int s0 = strobes;
    len_i = 3'(code); par_en_i = pen; par_odd_i = podd;
    hold(2);
    exp_data.push_back(dm);
    exp_fe.push_back(stopv ? 0 : 1);
    exp_pe.push_back((pen && bad) ? 1 : 0);
    rxd_i = 1'b0; hold(BIT);
    if (flip) begin  // R9: mid-frame settings change
      par_en_i = !pen; par_odd_i = !podd; len_i = 3'((code + 2) % 5);
    end
    for (int i = 0; i < nb; i++) begin
      if (i == glitch) begin  // R2: one sample-wide inversion
        rxd_i = dm[i]; hold(BIT/2 + 4);
        rxd_i = !dm[i]; hold(CPT);
        rxd_i = dm[i]; hold(BIT/2 - 4 - CPT);
      end else begin
        rxd_i = dm[i]; hold(BIT);
      end
    end
    if (pen) begin rxd_i = p; hold(BIT); end
    rxd_i = stopv; hold(BIT);
    for (int k = 1; k < nstop; k++) begin rxd_i = 1'b1; hold(BIT); end
    rxd_i = 1'b1;
    hold(4);
    chk("R7 one strobe per frame", strobes - s0, 1);
    len_i = 3'd3; par_en_i = 1'b0; par_odd_i = 1'b0;
  endtask

  initial begin
    int s0;
    hold(3);
    // R10 reset state
    chk("R10 valid", int'(valid_o), 0);
    chk("R10 data", int'(data_o), 0);
    chk("R10 flags", int'({frame_err_o, par_err_o}), 0);
    rst_ni = 1'b1; en_i = 1'b1;
    hold(BIT);

    send_frame(8'hA5, 3, 0, 0, 0, 1, 1, -1, 0);   // R3 8 bits
    send_frame(8'hFF, 0, 0, 0, 0, 1, 1, -1, 0);   // R3 5 bits, upper zero
    send_frame(7'h35, 2, 1, 0, 0, 1, 1, -1, 0);   // R4 even ok
    send_frame(6'h2B, 1, 1, 1, 0, 1, 1, -1, 0);   // R4 odd ok
    send_frame(8'h3C, 3, 1, 0, 1, 1, 1, -1, 0);   // R4 even bad
    send_frame(8'h81, 3, 1, 1, 1, 1, 1, -1, 0);   // R4 odd bad
    send_frame(9'h1C3, 7, 1, 1, 0, 1, 1, -1, 0);  // R3 code 7 -> 9 bits
    send_frame(9'h0F0, 4, 0, 0, 0, 1, 1, -1, 0);  // R3 code 4 -> 9 bits
    send_frame(8'h5A, 3, 0, 0, 0, 0, 1, -1, 0);   // R5 bad stop
    hold(BIT);
    send_frame(8'h66, 3, 1, 0, 0, 1, 2, -1, 0);   // R6 two stops
    send_frame(8'h99, 3, 0, 0, 0, 1, 1, -1, 0);   // R6 back to back
    send_frame(8'h6D, 3, 0, 0, 0, 1, 1, 3, 0);    // R2 glitch
    send_frame(8'h92, 3, 0, 0, 0, 1, 1, 0, 0);    // R2 glitch on bit 0
    send_frame(6'h15, 1, 1, 0, 1, 1, 1, -1, 1);   // R9 flip mid-frame

    // R1 start pulse too short for mid-bit
    s0 = strobes;
    rxd_i = 1'b0; hold(4 * CPT);
    rxd_i = 1'b1; hold(3 * BIT);
    chk("R1 false start no strobe", strobes - s0, 0);
    send_frame(8'h47, 3, 0, 0, 0, 1, 1, -1, 0);   // R1 recovers

    // R8 abort mid-frame
    s0 = strobes;
    rxd_i = 1'b0; hold(BIT);
    rxd_i = 1'b1; hold(BIT);
    rxd_i = 1'b0; hold(BIT/2);
    en_i = 1'b0; hold(8);
    rxd_i = 1'b1; hold(2 * BIT);
    en_i = 1'b1; hold(2 * BIT);
    chk("R8 aborted frame no strobe", strobes - s0, 0);
    send_frame(8'hC3, 3, 0, 0, 0, 1, 1, -1, 0);   // R8 fresh frame

    // R8 disabled: full frame ignored
    en_i = 1'b0;
    s0 = strobes;
    rxd_i = 1'b0; hold(BIT);
    for (int i = 0; i < 8; i++) begin rxd_i = i[0]; hold(BIT); end
    rxd_i = 1'b1; hold(2 * BIT);
    chk("R8 disabled no strobe", strobes - s0, 0);
    en_i = 1'b1; hold(BIT);

    chk("R7 queue drained", exp_data.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule